// File: doc/BRIEF.md
# Color Palette Host Access Sequencer

This block is the host-side access logic for a color lookup memory of 256 entries, each 18 bits wide. A host drives a 2-bit register select, active-low read and write strobes, and an 8-bit data bus. With these it can load or read back an auto-incrementing palette address, or stream red, green and blue components through a single data port. A hidden modulo-3 phase counter tracks which color component the next data-port access refers to.

For a write, the red and green bytes are staged internally. The blue byte completes the 18-bit word, which is committed at the current address, and the address then advances. For a read, the block first loads a read-mode address, which fetches that entry into a holding register. Three reads then return red, green and blue in turn. After the blue read the address advances and the next entry is fetched, so a host can stream through the palette without reloading the address. The block also holds a host-visible 8-bit pixel mask register.

All state runs on one clock. The strobes are sampled as single-cycle access pulses, and reset is synchronous.

Top module: `palette_host_seq`

## Requirements
- R1: A write with select 00 or 11 loads the address from din[7:0] and sets the phase to red. Select 00 leaves the block in write mode and select 11 leaves it in read mode.
- R2: Three data-port writes (select 01) in the order red, green, blue store the word {red, green, blue} at the current address. Red is bits 17:12, green is bits 11:6 and blue is bits 5:0. The address increments after the blue write.
- R3: After a read-mode address load, three data-port reads return red, green and blue of the entry at that address. The address then increments, and the next three reads return the following entry.
- R4: The phase counter advances on every data-port access, wraps from blue back to red, and can only be cleared by an address load.
- R5: Color components use din[5:0] on writes, and din[7:6] are ignored. On a color read, dout[5:0] carries the component and dout[7:6] are zero.
- R6: A blue access at address FFh leaves the address at 00h. In read mode, entry 00h is then fetched.
- R7: A read with select 00 or 11 returns the address on dout. It changes neither the address, the phase nor the read/write mode.
- R8: A cycle with both strobes low changes no state and leaves dout unchanged.
- R9: Select 10 reaches an 8-bit mask register. A write stores din and a read returns the stored value. Its reset value is FFh.
- R10: After reset, the address is 00h, the phase is red, the mode is write mode and dout is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 2 | Register select: 00 address/write mode, 01 data port, 10 mask, 11 address/read mode |
| rd_n | input | 1 | Active-low read strobe, one access per cycle held low |
| wr_n | input | 1 | Active-low write strobe, one access per cycle held low |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data, registered, holds the last read result |

## Verification
A strobe is sampled on a rising edge, and every state change it causes is visible one edge later. The read result appears on dout after that same edge and stays there until the next read. The bench therefore drives each strobe at a falling edge, releases it at the next falling edge, and samples dout at that same moment, a half period after the edge that produced it. The effects of address, phase and mode are checked only through later port accesses, each following the same one-edge rule.

// File: rtl/pal_pkg.sv
package pal_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR_WR = 2'b00,
    SEL_DATA    = 2'b01,
    SEL_MASK    = 2'b10,
    SEL_ADDR_RD = 2'b11
  } sel_t;

  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } phase_t;

  typedef struct packed {
    logic addr_load;
    logic load_rd;
    logic addr_read;
    logic data_wr;
    logic data_rd;
    logic mask_wr;
    logic mask_rd;
  } acc_t;

  localparam int NUM_COMP = 3;

endpackage

// File: rtl/pal_bus_decode.sv
module pal_bus_decode
  import pal_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       rd_n,
  input  logic       wr_n,
  output acc_t       acc
);

  logic do_wr;
  logic do_rd;
  logic is_addr;

  // Both strobes low is invalid: neither direction is decoded.
  assign do_wr   = !wr_n && rd_n;
  assign do_rd   = !rd_n && wr_n;
  assign is_addr = (sel == SEL_ADDR_WR) || (sel == SEL_ADDR_RD);

  always_comb begin
    acc           = '0;
    acc.addr_load = do_wr && is_addr;
    acc.load_rd   = (sel == SEL_ADDR_RD);
    acc.addr_read = do_rd && is_addr;
    acc.data_wr   = do_wr && (sel == SEL_DATA);
    acc.data_rd   = do_rd && (sel == SEL_DATA);
    acc.mask_wr   = do_wr && (sel == SEL_MASK);
    acc.mask_rd   = do_rd && (sel == SEL_MASK);
  end

endmodule

// File: rtl/pal_addr_phase.sv
module pal_addr_phase
  import pal_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_t              acc,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] addr_succ,
  output phase_t            phase,
  output logic              rd_mode,
  output logic              blue_step
);

  logic data_acc;

  assign data_acc  = acc.data_wr || acc.data_rd;
  assign blue_step = data_acc && (phase == PH_BLUE);
  assign addr_succ = addr + ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr    <= '0;
      phase   <= PH_RED;
      rd_mode <= 1'b0;
    end else if (acc.addr_load) begin
      addr    <= load_val;
      phase   <= PH_RED;
      rd_mode <= acc.load_rd;
    end else if (data_acc) begin
      unique case (phase)
        PH_RED:   phase <= PH_GREEN;
        PH_GREEN: phase <= PH_BLUE;
        default:  phase <= PH_RED;
      endcase
      if (phase == PH_BLUE) begin
        addr <= addr_succ;
      end
    end
  end

endmodule

// File: rtl/pal_color_mem.sv
module pal_color_mem #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/pal_rgb_stage.sv
module pal_rgb_stage
  import pal_pkg::*;
#(
  parameter int COMP_W = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  acc_t                         acc,
  input  phase_t                       phase,
  input  logic [COMP_W-1:0]            din_comp,
  input  logic                         fetch_en,
  input  logic [NUM_COMP*COMP_W-1:0]   fetch_word,
  output logic [NUM_COMP*COMP_W-1:0]   commit_word,
  output logic [COMP_W-1:0]            rd_comp
);

  localparam int WORD_W = NUM_COMP * COMP_W;

  logic [COMP_W-1:0] red_q;
  logic [COMP_W-1:0] green_q;
  logic [WORD_W-1:0] hold_q;
  logic [COMP_W-1:0] comp_arr [NUM_COMP];

  // Staging of the first two components of a write triple.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      red_q   <= '0;
      green_q <= '0;
    end else if (acc.data_wr) begin
      if (phase == PH_RED)   red_q   <= din_comp;
      if (phase == PH_GREEN) green_q <= din_comp;
    end
  end

  assign commit_word = {red_q, green_q, din_comp};

  // Holding register for read-mode component returns.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (fetch_en) begin
      hold_q <= fetch_word;
    end
  end

  // Component index 0 is red at the top of the word.
  for (genvar i = 0; i < NUM_COMP; i++) begin : g_comp
    assign comp_arr[i] = hold_q[WORD_W-1-i*COMP_W -: COMP_W];
  end

  always_comb begin
    unique case (phase)
      PH_RED:   rd_comp = comp_arr[0];
      PH_GREEN: rd_comp = comp_arr[1];
      default:  rd_comp = comp_arr[2];
    endcase
  end

endmodule

// File: rtl/palette_host_seq.sv
module palette_host_seq
  import pal_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int COMP_W = 6,
  parameter int BUS_W  = 8,
  parameter logic [BUS_W-1:0] MASK_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sel,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [BUS_W-1:0] din,
  output logic [BUS_W-1:0] dout
);

  localparam int WORD_W = NUM_COMP * COMP_W;

  acc_t              acc;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_succ;
  phase_t            phase_q;
  logic              rd_mode_q;
  logic              blue_step;
  logic [BUS_W-1:0]  mask_q;
  logic [WORD_W-1:0] commit_word;
  logic [WORD_W-1:0] mem_rdata;
  logic [ADDR_W-1:0] fetch_idx;
  logic              fetch_en;
  logic              mem_we;
  logic [COMP_W-1:0] rd_comp;
  logic [BUS_W-1:0]  addr_ext;
  logic [BUS_W-1:0]  comp_ext;

  pal_bus_decode u_dec (
    .sel  (sel),
    .rd_n (rd_n),
    .wr_n (wr_n),
    .acc  (acc)
  );

  pal_addr_phase #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .load_val  (din[ADDR_W-1:0]),
    .addr      (addr_q),
    .addr_succ (addr_succ),
    .phase     (phase_q),
    .rd_mode   (rd_mode_q),
    .blue_step (blue_step)
  );

  // Fetch target: the freshly loaded address, or the successor after blue.
  assign fetch_idx = acc.addr_load ? din[ADDR_W-1:0] : addr_succ;
  assign fetch_en  = (acc.addr_load && acc.load_rd) || (blue_step && rd_mode_q);
  assign mem_we    = acc.data_wr && (phase_q == PH_BLUE);

  pal_color_mem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (addr_q),
    .wdata (commit_word),
    .raddr (fetch_idx),
    .rdata (mem_rdata)
  );

  pal_rgb_stage #(.COMP_W(COMP_W)) u_rgb (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc         (acc),
    .phase       (phase_q),
    .din_comp    (din[COMP_W-1:0]),
    .fetch_en    (fetch_en),
    .fetch_word  (mem_rdata),
    .commit_word (commit_word),
    .rd_comp     (rd_comp)
  );

  always_comb begin
    addr_ext              = '0;
    addr_ext[ADDR_W-1:0]  = addr_q;
    comp_ext              = '0;
    comp_ext[COMP_W-1:0]  = rd_comp;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= MASK_RST;
    end else if (acc.mask_wr) begin
      mask_q <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout <= '0;
    end else if (acc.addr_read) begin
      dout <= addr_ext;
    end else if (acc.data_rd) begin
      dout <= comp_ext;
    end else if (acc.mask_rd) begin
      dout <= mask_q;
    end
  end

endmodule

// File: rtl/pal_host_checker.sv
module pal_host_checker #(
  parameter int ADDR_W = 8,
  parameter int COMP_W = 6,
  parameter int BUS_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        sel,
  input logic              rd_n,
  input logic              wr_n,
  input logic [BUS_W-1:0]  din,
  input logic [BUS_W-1:0]  dout,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        phase,
  input logic              rd_mode,
  input logic [BUS_W-1:0]  mask
);

  logic wr_ok, rd_ok, addr_sel;
  assign wr_ok    = !wr_n && rd_n;
  assign rd_ok    = !rd_n && wr_n;
  assign addr_sel = (sel[1] == sel[0]);

  assert_load_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && addr_sel) |=> (phase == 2'd0) && (addr == $past(din[ADDR_W-1:0]))
                            && (rd_mode == $past(sel[0])));

  assert_blue_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_ok || rd_ok) && sel == 2'b01 && phase == 2'd2)
      |=> addr == ADDR_W'($past(addr) + ADDR_W'(1)));

  assert_phase_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3);

  assert_color_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && sel == 2'b01) |=> dout[BUS_W-1:COMP_W] == '0);

  assert_addr_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && addr_sel) |=> $stable(addr) && $stable(phase) && $stable(rd_mode));

  assert_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !wr_n) |=> $stable(addr) && $stable(phase) && $stable(rd_mode)
                         && $stable(mask) && $stable(dout));

  assert_mask_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && sel == 2'b10) |=> mask == $past(din));

endmodule

bind palette_host_seq pal_host_checker #(
  .ADDR_W(ADDR_W), .COMP_W(COMP_W), .BUS_W(BUS_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sel     (sel),
  .rd_n    (rd_n),
  .wr_n    (wr_n),
  .din     (din),
  .dout    (dout),
  .addr    (addr_q),
  .phase   (phase_q),
  .rd_mode (rd_mode_q),
  .mask    (mask_q)
);

// File: tb/sim_palette_host_seq.sv
module sim_palette_host_seq;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       rd_n = 1'b1;
  logic       wr_n = 1'b1;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  palette_host_seq u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd_n(rd_n), .wr_n(wr_n),
    .din(din), .dout(dout)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    sel = s; din = d; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] s, output logic [7:0] q);
    @(negedge clk);
    sel = s; rd_n = 1'b0;
    @(negedge clk);
    rd_n = 1'b1;
    q = dout;
  endtask

  // Writes one entry; upper bus bits are set to prove they are ignored (R5).
  task automatic put_entry(input logic [7:0] a, input logic [5:0] r,
                           input logic [5:0] g, input logic [5:0] b);
    bus_wr(2'b00, a);
    bus_wr(2'b01, {2'b11, r});
    bus_wr(2'b01, {2'b10, g});
    bus_wr(2'b01, {2'b01, b});
  endtask

  task automatic expect_rgb(input string req, input logic [5:0] r,
                            input logic [5:0] g, input logic [5:0] b);
    logic [7:0] q;
    bus_rd(2'b01, q); check(req, "red",   q, {2'b00, r});
    bus_rd(2'b01, q); check(req, "green", q, {2'b00, g});
    bus_rd(2'b01, q); check(req, "blue",  q, {2'b00, b});
  endtask

  task automatic t_reset;
    logic [7:0] q;
    check("R10", "dout after reset", dout, 8'h00);
    bus_rd(2'b00, q); check("R10", "address after reset", q, 8'h00);
    bus_rd(2'b10, q); check("R9", "mask reset", q, 8'hFF);
  endtask

  task automatic t_write_read;
    logic [7:0] q;
    put_entry(8'h10, 6'h21, 6'h0A, 6'h3F);
    bus_wr(2'b01, 8'hC5); bus_wr(2'b01, 8'h16); bus_wr(2'b01, 8'h27);
    bus_wr(2'b01, 8'h00); bus_wr(2'b01, 8'h3F); bus_wr(2'b01, 8'h15);
    bus_rd(2'b00, q); check("R2", "address after three triples", q, 8'h13);
    bus_wr(2'b11, 8'h10);
    expect_rgb("R3", 6'h21, 6'h0A, 6'h3F);
    expect_rgb("R3", 6'h05, 6'h16, 6'h27);
    expect_rgb("R5", 6'h00, 6'h3F, 6'h15);
    bus_rd(2'b11, q); check("R3", "address after streamed reads", q, 8'h13);
  endtask

  task automatic t_phase;
    logic [7:0] q;
    bus_wr(2'b00, 8'h30);
    bus_wr(2'b01, 8'h01); bus_wr(2'b01, 8'h02);
    bus_wr(2'b00, 8'h30);          // reload clears the phase (R1)
    bus_wr(2'b01, 8'h11); bus_wr(2'b01, 8'h12); bus_wr(2'b01, 8'h13);
    bus_rd(2'b00, q); check("R1", "address after reload and triple", q, 8'h31);
    bus_wr(2'b11, 8'h30);
    expect_rgb("R1", 6'h11, 6'h12, 6'h13);
    // Address reads between components keep phase and mode (R7, R4).
    bus_wr(2'b11, 8'h11);
    bus_rd(2'b01, q); check("R4", "red of 11h", q, 8'h05);
    bus_rd(2'b01, q); check("R4", "green of 11h", q, 8'h16);
    bus_rd(2'b00, q); check("R7", "address read mid-triple", q, 8'h11);
    bus_rd(2'b11, q); check("R7", "second address read", q, 8'h11);
    bus_rd(2'b01, q); check("R7", "blue after address reads", q, 8'h27);
    bus_rd(2'b01, q); check("R7", "red of 12h keeps read mode", q, 8'h00);
  endtask

  task automatic t_wrap;
    logic [7:0] q;
    put_entry(8'h00, 6'h2A, 6'h15, 6'h33);
    put_entry(8'hFF, 6'h01, 6'h02, 6'h03);
    bus_rd(2'b00, q); check("R6", "address after write at FFh", q, 8'h00);
    bus_wr(2'b11, 8'hFF);
    expect_rgb("R6", 6'h01, 6'h02, 6'h03);
    bus_rd(2'b00, q); check("R6", "address after read at FFh", q, 8'h00);
    expect_rgb("R6", 6'h2A, 6'h15, 6'h33);
  endtask

  task automatic t_invalid;
    logic [7:0] q;
    bus_wr(2'b11, 8'h10);
    bus_rd(2'b01, q); check("R8", "red before invalid", q, 8'h21);
    @(negedge clk);
    sel = 2'b00; din = 8'h55; rd_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1;
    check("R8", "dout after invalid cycle", dout, 8'h21);
    @(negedge clk);
    sel = 2'b10; din = 8'h00; rd_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1;
    bus_rd(2'b00, q); check("R8", "address after invalid", q, 8'h10);
    bus_rd(2'b01, q); check("R8", "green after invalid", q, 8'h0A);
    bus_rd(2'b10, q); check("R8", "mask after invalid", q, 8'hFF);
  endtask

  task automatic t_mask;
    logic [7:0] q;
    bus_wr(2'b10, 8'h5A);
    bus_rd(2'b10, q); check("R9", "mask readback", q, 8'h5A);
    bus_wr(2'b10, 8'hA3);
    bus_rd(2'b10, q); check("R9", "mask second readback", q, 8'hA3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_phase();
    t_wrap();
    t_invalid();
    t_mask();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule